// File: doc/BRIEF.md
# Multi-Operand Add/Subtract Carry-Save Tree

This block sums a fixed set of equal-width two's-complement words in one pass. Each word is either added or subtracted, and the choice is made per word at elaboration. A small set of one-bit terms is added on top. The words are cut down by a tree of carry-save rows. A single carry-propagate adder then resolves the last two vectors, and the result is captured in an output register.

A subtracted word enters the tree bitwise inverted. The +1 that completes its negation is never given a row of its own. It occupies the free least-significant bit of some row's shifted carry vector, or the carry-in of the final adder. The one-bit operands use the same kind of slot. The +1 terms take the slots nearest the leaves, because they are ready at once. The one-bit operands take the slots nearest the root. A constant vector is added only when there are more one-bit terms than free slots.

Top module: `mcsa_sum_tree`

## Requirements
- R1: One clock edge after the inputs are applied, `result_o` equals the sum of all operand words, with each word negated where its subtract flag is set, plus every bit of `bits_i`, taken modulo 2^W.
- R2: When `rst` is high at a rising clock edge, `result_o` becomes zero. Operand values present during reset have no effect on the value seen after reset.
- R3: Operand k occupies bits `[k*W +: W]` of `ops_i`. Bit k of `SUB_MASK` set to 1 makes operand k subtracted, and 0 makes it added. The default is operands 0 and 1 added and operands 2 to 5 subtracted.
- R4: Every carry-save row preserves the sum. Its sum vector plus its carry vector, shifted left by one with the row's one-bit input at bit 0, equals the sum of its three input vectors plus that bit, modulo 2^W.
- R5: The final adder outputs its two vectors plus its carry-in bit, modulo 2^W.
- R6: Results that overflow wrap modulo 2^W. All-ones and most-negative operands give the wrapped value and no error.
- R7: Each bit of `bits_i` adds exactly 0 or 1 at weight 1, whatever the operand values.
- R8: With every operand zero and `bits_i` zero, the result is zero. The negation corrections of the subtracted words cancel exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ops_i | input | N_OPS*W | Packed operand words, operand k at [k*W +: W] |
| bits_i | input | N_BITS | One-bit addends of weight 1 |
| result_o | output | W | Registered signed-or-unsigned sum modulo 2^W |

## Verification
On every cycle the assertions check three things. Each carry-save row preserves the arithmetic sum across its carry-in slot. The final adder matches its inputs. The registered result matches a plain behavioural sum of the previous cycle's inputs. They also check that the result is zero on the first edge after reset. Only the bench scenarios can show that the flags select the intended operands: each word is driven alone in turn. The scenarios also exercise wraparound with all-ones and most-negative words, the weight of the one-bit operand, and the clearing of a mid-stream reset, each against hand-derived expected values.

// File: rtl/mcsa_pkg.sv
package mcsa_pkg;

  // More one-bit terms than free slots means an extra constant vector.
  function automatic bit need_const_vec(input int nops, input int nones, input int nbits);
    return (nones + nbits) > (nops - 1);
  endfunction

  function automatic int vec_count(input int nops, input int nones, input int nbits);
    return need_const_vec(nops, nones, nbits) ? nops + 1 : nops;
  endfunction

  // Number of +1 corrections that ride on carry-in slots.
  function automatic int ones_on_slots(input int nops, input int nones, input int nbits);
    return need_const_vec(nops, nones, nbits) ? nops - nbits : nones;
  endfunction

  // Value of the folded constant vector (leftover +1 corrections).
  function automatic int const_value(input int nops, input int nones, input int nbits);
    return need_const_vec(nops, nones, nbits) ? nones + nbits - nops : 0;
  endfunction

endpackage

// File: rtl/mcsa_full_add.sv
module mcsa_full_add (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);

  logic ab_x;

  assign ab_x = a_i ^ b_i;
  assign s_o  = ab_x ^ c_i;
  assign co_o = (a_i & b_i) | (ab_x & c_i);

endmodule

// File: rtl/mcsa_csa_row.sv
module mcsa_csa_row #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  localparam int LOW_BITS = W - 1;

  logic [LOW_BITS-1:0] maj;

  // Independent full adders, no propagation between positions.
  for (genvar i = 0; i < LOW_BITS; i++) begin : g_bit
    mcsa_full_add u_fa (
      .a_i (x_i[i]),
      .b_i (y_i[i]),
      .c_i (z_i[i]),
      .s_o (sum_o[i]),
      .co_o(maj[i])
    );
  end

  // Top bit: its carry would leave the W-bit window.
  assign sum_o[W-1] = x_i[W-1] ^ y_i[W-1] ^ z_i[W-1];

  // Shift carries up one place; the vacated LSB holds the one-bit input.
  assign carry_o = {maj, cin_i};

  AST_ROW_CONSERVES: assert property (@(posedge clk) disable iff (rst)
    W'(sum_o + carry_o) == W'(x_i + y_i + z_i + {{(W-1){1'b0}}, cin_i})); // R4

endmodule

// File: rtl/mcsa_final_add.sv
module mcsa_final_add #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < W - 1; i++) begin : g_rip
    mcsa_full_add u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (chain[i]),
      .s_o (sum_o[i]),
      .co_o(chain[i+1])
    );
  end

  assign sum_o[W-1] = a_i[W-1] ^ b_i[W-1] ^ chain[W-1];

  AST_FINAL_ADD: assert property (@(posedge clk) disable iff (rst)
    sum_o == W'(a_i + b_i + {{(W-1){1'b0}}, cin_i})); // R5

endmodule

// File: rtl/mcsa_operand_prep.sv
module mcsa_operand_prep #(
  parameter int              W         = 16,
  parameter int              N_OPS     = 6,
  parameter logic [N_OPS-1:0] SUB_MASK = '0,
  parameter int              NV        = 6,
  parameter int              CONST_VAL = 0
) (
  input  logic [N_OPS*W-1:0]     ops_i,
  output logic [NV-1:0][W-1:0]   prep_o
);

  localparam int OFS = NV - N_OPS;

  // The folded constant (if any) sits first: zero delay, consumed early.
  if (OFS == 1) begin : g_const
    assign prep_o[0] = W'(CONST_VAL);
  end

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    if (SUB_MASK[k]) begin : g_neg
      assign prep_o[OFS+k] = ~ops_i[k*W +: W];
    end else begin : g_pos
      assign prep_o[OFS+k] = ops_i[k*W +: W];
    end
  end

endmodule

// File: rtl/mcsa_sum_tree.sv
module mcsa_sum_tree #(
  parameter int               W        = 16,
  parameter int               N_OPS    = 6,
  parameter logic [N_OPS-1:0] SUB_MASK = 6'b111100,
  parameter int               N_BITS   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_OPS*W-1:0] ops_i,
  input  logic [N_BITS-1:0]  bits_i,
  output logic [W-1:0]       result_o
);

  import mcsa_pkg::*;

  localparam int N_ONES    = $countones(SUB_MASK);
  localparam int NV        = vec_count(N_OPS, N_ONES, N_BITS);
  localparam int NS        = NV - 2;
  localparam int N_NODES   = NV + 2 * NS;
  localparam int ONES_SLOT = ones_on_slots(N_OPS, N_ONES, N_BITS);
  localparam int CONST_VAL = const_value(N_OPS, N_ONES, N_BITS);
  localparam int FIRST_BIT = NS + 1 - N_BITS;

  if (W < 2 || N_OPS < 2 || N_BITS < 1 || N_BITS > N_OPS - 1) begin : g_bad_cfg
    $error("mcsa_sum_tree: unsupported parameter set");
  end

  // Node pool in creation order; creation order is arrival order.
  logic [N_NODES-1:0][W-1:0] node;
  logic [NS:0]               slot;
  logic [W-1:0]              tree_sum;
  logic [W-1:0]              result_q;

  mcsa_operand_prep #(
    .W        (W),
    .N_OPS    (N_OPS),
    .SUB_MASK (SUB_MASK),
    .NV       (NV),
    .CONST_VAL(CONST_VAL)
  ) u_prep (
    .ops_i (ops_i),
    .prep_o(node[NV-1:0])
  );

  // Slot j = carry-in of row j (j < NS) or of the final adder (j == NS).
  // Leaves take the +1 corrections, the root takes the live bits.
  for (genvar j = 0; j <= NS; j++) begin : g_slot
    if (j >= FIRST_BIT) begin : g_live
      assign slot[j] = bits_i[j-FIRST_BIT];
    end else if (j < ONES_SLOT) begin : g_one
      assign slot[j] = 1'b1;
    end else begin : g_nil
      assign slot[j] = 1'b0;
    end
  end

  // Row s takes the three oldest unconsumed nodes, appends two new ones.
  for (genvar s = 0; s < NS; s++) begin : g_row
    mcsa_csa_row #(.W(W)) u_row (
      .clk    (clk),
      .rst    (rst),
      .x_i    (node[3*s]),
      .y_i    (node[3*s+1]),
      .z_i    (node[3*s+2]),
      .cin_i  (slot[s]),
      .sum_o  (node[NV+2*s]),
      .carry_o(node[NV+2*s+1])
    );
  end

  mcsa_final_add #(.W(W)) u_cpa (
    .clk  (clk),
    .rst  (rst),
    .a_i  (node[N_NODES-2]),
    .b_i  (node[N_NODES-1]),
    .cin_i(slot[NS]),
    .sum_o(tree_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) result_q <= '0;
    else     result_q <= tree_sum;
  end

  assign result_o = result_q;

  // Behavioural reference, separate from the tree.
  logic [W-1:0] ref_sum;
  always_comb begin
    ref_sum = '0;
    for (int k = 0; k < N_OPS; k++) begin
      if (SUB_MASK[k]) ref_sum = ref_sum - ops_i[k*W +: W];
      else             ref_sum = ref_sum + ops_i[k*W +: W];
    end
    for (int b = 0; b < N_BITS; b++) ref_sum = ref_sum + W'(bits_i[b]);
  end

  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> result_q == $past(ref_sum)); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> result_q == '0); // R2

endmodule

// File: tb/mcsa_sum_tree_tb.sv
`timescale 1ns/1ps
module mcsa_sum_tree_tb;

  localparam int W      = 16;
  localparam int N_OPS  = 6;
  localparam int N_BITS = 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [N_OPS*W-1:0] ops_i = '0;
  logic [N_BITS-1:0]  bits_i = '0;
  logic [W-1:0]       result_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  mcsa_sum_tree #(
    .W(W), .N_OPS(N_OPS), .SUB_MASK(6'b111100), .N_BITS(N_BITS)
  ) u_dut (
    .clk(clk), .rst(rst), .ops_i(ops_i), .bits_i(bits_i), .result_o(result_o)
  );

  // R3 default: operands 0,1 added; 2..5 subtracted.
  function automatic logic [W-1:0] model(input logic [W-1:0] o [N_OPS], input logic b);
    logic [W-1:0] acc;
    acc = o[0] + o[1] - o[2] - o[3] - o[4] - o[5];
    return acc + W'(b);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Driver: applies one item at the falling edge and queues its expectation.
  task automatic drive(input logic [W-1:0] o [N_OPS], input logic b, input string req);
    @(negedge clk);
    for (int k = 0; k < N_OPS; k++) ops_i[k*W +: W] = o[k];
    bits_i[0] = b;
    exp_q.push_back(model(o, b));
    tag_q.push_back(req);
  endtask

  // Monitor: the register updates at the rising edge; compare just after.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), result_o, exp_q.pop_front());
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] o [N_OPS];

    // R2: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset value", result_o, '0);
    rst = 1'b0;

    // R8: all zero, corrections cancel
    for (int k = 0; k < N_OPS; k++) o[k] = '0;
    drive(o, 1'b0, "R8 all zero");

    // R6: all ones -> -1-1+4 = 2
    for (int k = 0; k < N_OPS; k++) o[k] = '1;
    drive(o, 1'b0, "R6 all ones");
    drive(o, 1'b1, "R6 all ones plus bit");

    // R6: most negative everywhere wraps to 0
    for (int k = 0; k < N_OPS; k++) o[k] = 16'h8000;
    drive(o, 1'b0, "R6 most negative");

    // R6: large positive overflow
    o[0] = 16'h7fff; o[1] = 16'h7fff;
    for (int k = 2; k < N_OPS; k++) o[k] = '0;
    drive(o, 1'b0, "R6 positive overflow");

    // R3: each operand alone, sign from its flag
    for (int i = 0; i < N_OPS; i++) begin
      for (int k = 0; k < N_OPS; k++) o[k] = '0;
      o[i] = 16'h1234 + 16'(i);
      drive(o, 1'b0, "R3 single operand sign");
    end

    // R7: one-bit operand weight
    for (int k = 0; k < N_OPS; k++) o[k] = '0;
    drive(o, 1'b1, "R7 bit alone");
    o[2] = 16'h0001;
    drive(o, 1'b1, "R7 bit cancels subtracted one");

    // R1: random traffic, back to back
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < N_OPS; k++) o[k] = W'($urandom);
      drive(o, 1'($urandom), "R1 random");
    end
    drain();

    // R2: reset mid-stream with busy inputs
    @(negedge clk);
    for (int k = 0; k < N_OPS; k++) ops_i[k*W +: W] = 16'h5a5a;
    bits_i = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R2 mid-stream reset", result_o, '0);
    rst = 1'b0;

    // R1: operation resumes after reset
    for (int k = 0; k < N_OPS; k++) o[k] = 16'(k * 16'h0111);
    drive(o, 1'b1, "R1 after reset");
    drain();

    finish_run();
  end

endmodule